// File: doc/BRIEF.md
# Rotating Three-Port Byte Target for a Two-Wire Serial Bus

This block is the serial-bus front end of a 24-bit remote I/O expander. It watches the SCL and SDA lines as an I2C target. It compares the received address byte with an address chosen by three select inputs, and it acknowledges only when the two are equal. On a write, the data bytes that follow are spread over three 8-bit output latches in a fixed rotating order. Each byte reaches its latch as soon as its acknowledge clock ends.

On a read, the block returns pin values. Each byte is a sample of one port's pins, taken when the byte starts, and the bytes follow the same rotation as a write. A transfer may run for any number of bytes. A STOP may come after any byte, and every byte already committed stays in place.

Each select input is a 2-bit code that names its tie-off: 00 ground, 01 supply, 10 SCL, 11 SDA. Together the three codes pick one of 64 target addresses. Each committed byte produces a one-cycle write strobe for its port, and each read sample produces a one-cycle read strobe for its port.

Top module: `iox24_i2c_target`

## Requirements
- R1: After a START, the first byte holds the 7-bit target address, most significant bit first, followed by a direction bit: 1 means read and 0 means write. When the address matches, the target pulls SDA low during the ninth clock.
- R2: The 6-bit index n = {sel2_i, sel1_i, sel0_i} selects the address. For n from 0 to 31 the address is 0x10+n. For n from 32 to 55 it is 0x50+(n-32). For n from 56 to 63 it is 0x70+(n-56).
- R3: If the address does not match, the target gives no acknowledge. It then ignores the bus until the next START, so the latches do not change and later bytes are not acknowledged.
- R4: The target acknowledges every written data byte. The byte is written into its latch only on the SCL falling edge that ends its acknowledge clock, and wr_stb_o pulses on that port's bit for one cycle. While the acknowledge clock is still high, the latch still holds its old value.
- R5: Written bytes go to port 0, then port 1, then port 2, and the order then wraps to port 0. There is no limit on the byte count, and each later byte overwrites its port. Port k occupies latch_o[8k+7:8k].
- R6: Read bytes follow the same port rotation. Each byte is pin_i[8k+7:8k], sampled at the SCL falling edge that ends the previous acknowledge clock. The sample is taken after the address acknowledge for the first byte and after the controller's acknowledge for each later byte. Each sample pulses rd_stb_o[k] for one cycle.
- R7: A controller NACK ends a read, and the target releases SDA. A STOP after any byte releases SDA and returns the target to idle, and every byte already committed is kept.
- R8: A repeated START resets the rotation, so the next data byte goes to port 0.
- R9: While rst_n is low at a clock edge, the design does the following from the next edge: all latch bits read 1, SDA is released, and no strobe is raised.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| sel0_i | input | 2 | Address select 0 tie-off code |
| sel1_i | input | 2 | Address select 1 tie-off code |
| sel2_i | input | 2 | Address select 2 tie-off code |
| pin_i | input | 24 | Port pin levels, port k at bits 8k+7:8k |
| latch_o | output | 24 | Output latch contents, port k at bits 8k+7:8k |
| wr_stb_o | output | 3 | One-cycle pulse per port when a byte is committed |
| rd_stb_o | output | 3 | One-cycle pulse per port when a byte is sampled for reading |

## Verification
Some properties are checked on every cycle. The strobes are at most one-hot. The latches hold still whenever no write strobe is raised. A write strobe happens only while SCL is low. The SDA drive never changes during an SCL high phase. The reset values are also checked.

Other behaviour only the bench scenarios can show. These are the address match and the decoding of the select codes, the rotation and its wrap across long streams, and the per-byte pin sample taken at the acknowledge edge. They also include the rejection of a foreign address, the reset of the rotation by a repeated START, and the partial group left behind when a STOP comes mid-stream.

// File: rtl/iox24_pkg.sv
// Shared types and the select-code address function for the expander target.
// Assumes an 8-bit byte on the bus and 2-bit tie-off codes per select input.
package iox24_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WDATA,
        PH_WACK,
        PH_RDATA,
        PH_RACK
    } phase_t;

    // Map the 6-bit select index onto the 64-entry target address space.
    function automatic logic [6:0] sel_to_addr(input logic [5:0] code);
        logic [6:0] c;
        c = {1'b0, code};
        if (code < 6'd32) begin
            return 7'h10 + c;
        end else if (code < 6'd56) begin
            return 7'h50 + (c - 7'd32);
        end else begin
            return 7'h70 + (c - 7'd56);
        end
    endfunction

endpackage

// File: rtl/iox24_line_sync.sv
// Synchronises SCL and SDA into the system clock and detects bus events.
// Assumes clk is several times faster than SCL; reset state is an idle bus.
module iox24_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // Shift both lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    // Decode clock edges and SDA transitions while SCL stays high.
    always_comb begin
        sda_s_o    = sda_s;
        scl_rise_o = scl_s & ~scl_q;
        scl_fall_o = ~scl_s & scl_q;
        start_o    = scl_s & scl_q & sda_q & ~sda_s;
        stop_o     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/iox24_xfer_fsm.sv
// Byte-level target state machine: address match, acknowledge, write
// distribution and read serialisation with a rotating port index.
// Assumes clean single-cycle event pulses from iox24_line_sync.
module iox24_xfer_fsm
    import iox24_pkg::*;
#(
    parameter int PORTS = 3,
    localparam int PIN_W = PORTS * BYTE_W,
    localparam int IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [6:0]        own_addr,
    input  logic [PIN_W-1:0]  pins,
    output logic              sda_drive,
    output logic [PORTS-1:0]  wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [PORTS-1:0]  rd_stb
);

    phase_t             phase;
    logic [BYTE_W-1:0]  shreg;
    logic [3:0]         bitcnt;
    logic               rw;
    logic               mack;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   idx_next;
    logic [BYTE_W-1:0]  pin_byte;

    // Next port in the rotation and the current port's pin byte.
    always_comb begin
        idx_next = (idx == IDX_W'(PORTS - 1)) ? '0 : idx + 1'b1;
        pin_byte = pins[idx*BYTE_W +: BYTE_W];
    end

    // Advance the transfer on each bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            idx       <= '0;
            sda_drive <= 1'b0;
            wr_stb    <= '0;
            wr_byte   <= '0;
            rd_stb    <= '0;
        end else begin
            wr_stb <= '0;
            rd_stb <= '0;
            if (start_ev) begin
                phase     <= PH_ADDR;
                bitcnt    <= '0;
                idx       <= '0;
                sda_drive <= 1'b0;
            end else if (stop_ev) begin
                phase     <= PH_IDLE;
                sda_drive <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_WDATA: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (phase == PH_ADDR) begin
                                if (shreg[7:1] == own_addr) begin
                                    sda_drive <= 1'b1;
                                    rw        <= shreg[0];
                                    phase     <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                sda_drive <= 1'b1;
                                phase     <= PH_WACK;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg     <= pin_byte;
                                sda_drive <= ~pin_byte[BYTE_W-1];
                                rd_stb    <= PORTS'(1) << idx;
                                idx       <= idx_next;
                                phase     <= PH_RDATA;
                            end else begin
                                sda_drive <= 1'b0;
                                phase     <= PH_WDATA;
                            end
                        end
                    end
                    PH_WACK: begin
                        if (scl_fall) begin
                            sda_drive <= 1'b0;
                            wr_byte   <= shreg;
                            wr_stb    <= PORTS'(1) << idx;
                            idx       <= idx_next;
                            bitcnt    <= '0;
                            phase     <= PH_WDATA;
                        end
                    end
                    PH_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_drive <= 1'b0;
                                phase     <= PH_RACK;
                            end else begin
                                shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_drive <= ~shreg[BYTE_W-2];
                                bitcnt    <= bitcnt + 4'd1;
                            end
                        end
                    end
                    PH_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg     <= pin_byte;
                                sda_drive <= ~pin_byte[BYTE_W-1];
                                rd_stb    <= PORTS'(1) << idx;
                                idx       <= idx_next;
                                bitcnt    <= '0;
                                phase     <= PH_RDATA;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: begin
                        phase <= PH_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/iox24_port_bank.sv
// One 8-bit output latch per port, loaded by its own write strobe.
// Assumes wr_stb is at most one-hot; all latches reset high.
module iox24_port_bank
    import iox24_pkg::*;
#(
    parameter int PORTS = 3,
    localparam int PIN_W = PORTS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORTS-1:0]  wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [PIN_W-1:0]  latch_o
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic [BYTE_W-1:0] lat;

        // Hold or load this port's latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat <= '1;
            end else if (wr_stb[p]) begin
                lat <= wr_byte;
            end
        end

        assign latch_o[p*BYTE_W +: BYTE_W] = lat;
    end

endmodule

// File: rtl/iox24_i2c_target.sv
// Top of the expander target: bus synchroniser, transfer engine, latches.
// Assumes the select codes are static during a transfer.
module iox24_i2c_target
    import iox24_pkg::*;
#(
    parameter int PORTS       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = PORTS * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_drive_low_o,
    input  logic [1:0]       sel0_i,
    input  logic [1:0]       sel1_i,
    input  logic [1:0]       sel2_i,
    input  logic [PIN_W-1:0] pin_i,
    output logic [PIN_W-1:0] latch_o,
    output logic [PORTS-1:0] wr_stb_o,
    output logic [PORTS-1:0] rd_stb_o
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_ev;
    logic              stop_ev;
    logic [6:0]        own_addr;
    logic [BYTE_W-1:0] wr_byte;

    // Derive this target's address from the three tie-off codes.
    always_comb begin
        own_addr = sel_to_addr({sel2_i, sel1_i, sel0_i});
    end

    iox24_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    iox24_xfer_fsm #(.PORTS(PORTS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .own_addr  (own_addr),
        .pins      (pin_i),
        .sda_drive (sda_drive_low_o),
        .wr_stb    (wr_stb_o),
        .wr_byte   (wr_byte),
        .rd_stb    (rd_stb_o)
    );

    iox24_port_bank #(.PORTS(PORTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb_o),
        .wr_byte (wr_byte),
        .latch_o (latch_o)
    );

endmodule

// File: rtl/iox24_i2c_target_chk.sv
// Cycle-level properties of the expander target, bound to its top.
// Assumes the same PORTS value as the bound instance.
module iox24_i2c_target_chk #(
    parameter int PORTS = 3,
    localparam int PIN_W = PORTS * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_drive_low_o,
    input logic [PIN_W-1:0] latch_o,
    input logic [PORTS-1:0] wr_stb_o,
    input logic [PORTS-1:0] rd_stb_o
);

    // R9: reset values appear on the edge after a low reset sample.
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (latch_o == '1 && !sda_drive_low_o && wr_stb_o == '0 && rd_stb_o == '0));

    // R5: one port written at a time.
    p_wr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));

    // R6: one port sampled at a time.
    p_rd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb_o));

    // R4: latches move only after a write strobe.
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o == '0) |=> $stable(latch_o));

    // R4: commits happen after the acknowledge clock has fallen.
    p_commit_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o != '0) |-> !scl_i);

    // R10: SDA drive changes only while SCL is low.
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low_o != $past(sda_drive_low_o)) |-> !$past(scl_i));

endmodule

bind iox24_i2c_target iox24_i2c_target_chk #(.PORTS(PORTS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_i),
    .sda_drive_low_o (sda_drive_low_o),
    .latch_o         (latch_o),
    .wr_stb_o        (wr_stb_o),
    .rd_stb_o        (rd_stb_o)
);

// File: tb/iox24_i2c_target_bench.sv
// Self-checking bench: a bus controller model drives directed and random
// transfers; expected latch and read values come from a bench-side model.
module iox24_i2c_target_bench;

    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m;
    logic        sda_m;
    logic [1:0]  s0, s1, s2;
    logic [23:0] pins;
    logic        sda_drv;
    logic [23:0] latch;
    logic [2:0]  wstb, rstb;
    logic        sda_line;
    logic [2:0]  wseen, rseen;
    logic [23:0] exp_lat;
    int          exp_idx;
    int          checks = 0;
    int          fails  = 0;
    int          viol   = 0;
    logic        prev_drv;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_drv;

    iox24_i2c_target u_iox24_i2c_target (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .sda_drive_low_o (sda_drv),
        .sel0_i          (s0),
        .sel1_i          (s1),
        .sel2_i          (s2),
        .pin_i           (pins),
        .latch_o         (latch),
        .wr_stb_o        (wstb),
        .rd_stb_o        (rstb)
    );

    // Collect strobes seen since the last clear.
    always @(posedge clk) begin
        wseen <= wseen | wstb;
        rseen <= rseen | rstb;
    end

    // R10 monitor: drive changes observed while SCL is high.
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_drv !== prev_drv) viol++;
        prev_drv <= sda_drv;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] addr_of(input int n);
        if (n <= 31) return 7'(16 + n);
        else if (n <= 55) return 7'(48 + n);
        else return 7'(56 + n);
    endfunction

    task automatic set_sel(input int n);
        s0 = 2'(n);
        s1 = 2'(n >> 2);
        s2 = 2'(n >> 4);
        tick(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack, output logic [23:0] mid);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line;
        mid = latch;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = !mack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write n random bytes to address a, tracking the expected latches.
    task automatic write_stream(input logic [6:0] a, input int n);
        bit ack;
        logic [23:0] mid;
        logic [7:0] b;
        bus_start();
        put_byte({a, 1'b0}, ack, mid);
        chk(ack, "R1 write address ack", 32'(ack), 1);
        exp_idx = 0;
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom);
            put_byte(b, ack, mid);
            chk(ack, "R4 data ack", 32'(ack), 1);
            exp_lat[exp_idx*8 +: 8] = b;
            exp_idx = (exp_idx + 1) % 3;
        end
        bus_stop();
        chk(latch == exp_lat, "R5 latch stream", 32'(latch), 32'(exp_lat));
    endtask

    // Read n bytes from address a, changing pins after each byte.
    task automatic read_stream(input logic [6:0] a, input int n);
        bit ack;
        logic [23:0] mid;
        logic [23:0] snap;
        logic [7:0] b;
        int ri;
        bus_start();
        put_byte({a, 1'b1}, ack, mid);
        chk(ack, "R1 read address ack", 32'(ack), 1);
        snap = pins;
        ri = 0;
        for (int k = 0; k < n; k++) begin
            get_byte(b, k < n - 1);
            chk(b == snap[ri*8 +: 8], "R6 read byte", 32'(b), 32'(snap[ri*8 +: 8]));
            ri = (ri + 1) % 3;
            snap = pins;
            pins = 24'($urandom);
        end
        tick(4);
        chk(!sda_drv, "R7 release after nack", 32'(sda_drv), 0);
        bus_stop();
    endtask

    initial begin
        tick(190000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit ack;
        logic [23:0] mid;
        logic [7:0] b;
        logic [6:0] a;
        int codes[5];
        void'($urandom(32'd4242));
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; pins = 24'h5A3C96;
        s0 = 2'd0; s1 = 2'd0; s2 = 2'd0;
        prev_drv = 1'b0; wseen = '0; rseen = '0;
        tick(5);
        chk(latch == 24'hFFFFFF, "R9 reset latches", 32'(latch), 32'hFFFFFF);
        chk(!sda_drv && wstb == 0 && rstb == 0, "R9 reset drive/strobes", 32'({sda_drv, wstb, rstb}), 0);
        rst_n = 1'b1;
        tick(5);
        exp_lat = 24'hFFFFFF;

        // Directed three-byte write with commit timing.
        set_sel(5);
        a = addr_of(5);
        wseen = '0;
        bus_start();
        put_byte({a, 1'b0}, ack, mid);
        chk(ack, "R1 address ack", 32'(ack), 1);
        put_byte(8'hA1, ack, mid);
        chk(mid[7:0] == 8'hFF, "R4 latch unchanged during ack clock", 32'(mid[7:0]), 32'hFF);
        chk(latch[7:0] == 8'hA1, "R4 commit after ack", 32'(latch[7:0]), 32'hA1);
        chk(wseen == 3'b001, "R4 port0 write strobe", 32'(wseen), 1);
        put_byte(8'hB2, ack, mid);
        put_byte(8'hC3, ack, mid);
        bus_stop();
        chk(latch == 24'hC3B2A1, "R5 three-port order", 32'(latch), 32'hC3B2A1);
        chk(wseen == 3'b111, "R4 all write strobes", 32'(wseen), 7);
        exp_lat = latch;

        // Wrap: five bytes overwrite port0 and port1.
        write_stream(a, 5);

        // Foreign address is ignored.
        bus_start();
        put_byte({a ^ 7'h04, 1'b0}, ack, mid);
        chk(!ack, "R3 no ack on mismatch", 32'(ack), 0);
        put_byte(8'h00, ack, mid);
        chk(!ack, "R3 data ignored after mismatch", 32'(ack), 0);
        bus_stop();
        chk(latch == exp_lat, "R3 latches untouched", 32'(latch), 32'(exp_lat));

        // Read with pin snapshots at each acknowledge.
        rseen = '0;
        read_stream(a, 4);
        chk(rseen == 3'b111, "R6 read strobes", 32'(rseen), 7);

        // Repeated START resets rotation.
        bus_start();
        put_byte({a, 1'b0}, ack, mid);
        put_byte(8'h11, ack, mid);
        bus_start();
        put_byte({a, 1'b0}, ack, mid);
        chk(ack, "R8 ack after repeated start", 32'(ack), 1);
        put_byte(8'h22, ack, mid);
        put_byte(8'h33, ack, mid);
        bus_stop();
        exp_lat[15:0] = 16'h3322;
        chk(latch == exp_lat, "R8 rotation restarted", 32'(latch), 32'(exp_lat));

        // STOP mid-group keeps committed bytes.
        bus_start();
        put_byte({a, 1'b0}, ack, mid);
        put_byte(8'h44, ack, mid);
        put_byte(8'h55, ack, mid);
        bus_stop();
        exp_lat[15:0] = 16'h5544;
        chk(latch == exp_lat, "R7 partial group kept", 32'(latch), 32'(exp_lat));
        chk(!sda_drv, "R7 released after stop", 32'(sda_drv), 0);

        // Select-code boundaries.
        codes = '{0, 31, 32, 55, 63};
        foreach (codes[i]) begin
            set_sel(codes[i]);
            bus_start();
            put_byte({addr_of(codes[i]), 1'b0}, ack, mid);
            bus_stop();
            chk(ack, "R2 select code address", 32'(codes[i]), 32'(addr_of(codes[i])));
        end
        set_sel(56);
        bus_start();
        put_byte({addr_of(55), 1'b0}, ack, mid);
        bus_stop();
        chk(!ack, "R2 neighbour address rejected", 32'(ack), 0);

        // Random mix.
        for (int it = 0; it < 6; it++) begin
            int n;
            n = int'($urandom % 64);
            set_sel(n);
            write_stream(addr_of(n), 1 + int'($urandom % 7));
            pins = 24'($urandom);
            read_stream(addr_of(n), 1 + int'($urandom % 5));
        end

        chk(viol == 0, "R10 drive changes with SCL high", 32'(viol), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule